// File: doc/BRIEF.md
# Serial Bit-Oriented Frame Receiver

The block takes a serial line sampled on a one-cycle bit-rate enable. It finds the 01111110 delimiter, removes the zero bits inserted after runs of five ones, and builds bytes from the least significant bit up. It runs the 16-bit frame check across every payload bit and reports each finished frame on a byte stream. The first delivered byte of a frame carries a start marker. A separate one-cycle end strobe then carries a five-bit error vector.

The same end strobe reports aborts, frames that stop on a partial byte, frames that are too short, frames whose running byte count passes a 16-bit limit, and frames whose check residue is wrong. A pass-through input chooses whether the two trailing check bytes are delivered as data or stripped. After an abort or a limit overrun the receiver drops the rest of the line until it finds the next delimiter.

Top module: `hdlc_rx_framer`

## Requirements
- R1: A frame is the bits between two 01111110 delimiters. Each frame that holds at least one payload bit produces exactly one end strobe. Adjacent delimiters, and an idle run of ones after a delimiter, produce no strobe.
- R2: Inside a frame, a 0 that follows five consecutive 1s is removed before byte assembly, so payload bytes such as 0xFF and 0x7E come through unchanged.
- R3: Bytes are assembled with the first received bit as bit 0. `out_sof` is high only together with `out_valid`, and only on the first byte delivered for a frame.
- R4: The check runs the reflected CRC-16 with polynomial 0x8408, seeded with 0xFFFF. A frame closed by a delimiter whose residue is not 0xF0B8 sets error bit 4.
- R5: With `fcs_pass` high, all received bytes are delivered, including the two check bytes. With it low, the last two bytes of a frame are not delivered.
- R6: Seven consecutive 1s inside a frame that already holds payload bits end the frame. The error vector is then exactly bit 0, and the receiver searches for a delimiter.
- R7: A frame closed by a delimiter whose payload bit count is not a multiple of eight sets error bit 1.
- R8: A frame closed by a delimiter with fewer than 5 bytes, check bytes included, sets error bit 2.
- R9: When the frame's byte count, check bytes included, would exceed `byte_limit`, the byte that passes the limit is dropped and the frame ends with error vector exactly bit 3. No more than `byte_limit` bytes of that frame are delivered, and the next delimiter starts a normal frame.
- R10: `out_eof` is a one-cycle strobe with `out_valid` low. `out_err` is zero in every other cycle.
- R11: While reset is held, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bit_en | input | 1 | One-cycle enable marking a valid line bit |
| rx_bit | input | 1 | Serial line bit |
| fcs_pass | input | 1 | 1: deliver check bytes as data; 0: strip them |
| byte_limit | input | 16 | Largest allowed byte count per frame |
| out_valid | output | 1 | Delivered byte valid |
| out_data | output | 8 | Delivered byte |
| out_sof | output | 1 | First delivered byte of a frame |
| out_eof | output | 1 | End-of-frame strobe |
| out_err | output | 5 | Error vector, valid with `out_eof` |

## Verification
The hardest case to reach is a limit overrun in the middle of a frame. The line keeps sending bytes and a closing delimiter after the receiver has already given up. The stimulus lowers `byte_limit` below the length of a well-formed frame and sends the whole frame. It then checks that exactly the allowed bytes and one overrun strobe come out, and that a clean frame after it is received normally. An abort placed after a partial byte and a frame padded with three stray bits cover the other early-termination paths.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;
  localparam int BYTE_W    = 8;
  localparam int ERR_W     = 5;
  localparam int E_ABORT   = 0;
  localparam int E_NONOCT  = 1;
  localparam int E_SHORT   = 2;
  localparam int E_OVF     = 3;
  localparam int E_CRC     = 4;
  localparam int FLAG_RUN  = 6;             // ones inside a delimiter
  localparam int CRC_W     = 16;
  localparam logic [CRC_W-1:0] CRC_POLY_R = 16'h8408;
  localparam logic [CRC_W-1:0] CRC_SEED   = 16'hFFFF;
  localparam logic [CRC_W-1:0] CRC_GOOD   = 16'hF0B8;

  typedef enum logic {ST_HUNT, ST_FRAME} rx_state_e;
  typedef enum logic [1:0] {SYM_NONE, SYM_DATA, SYM_FLAG, SYM_ABORT} sym_e;
endpackage

// File: rtl/hdlc_rx_bitproc.sv
// Classifies each enabled line bit: payload bit, delimiter, abort or dropped.
module hdlc_rx_bitproc
  import hdlc_rx_pkg::*;
#(
  parameter int RUN = FLAG_RUN
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic rx_bit,
  output sym_e sym
);
  localparam int OW = $clog2(RUN + 2);
  localparam logic [OW-1:0] ONE_RUN  = OW'(RUN);
  localparam logic [OW-1:0] STUF_RUN = OW'(RUN - 1);
  localparam logic [OW-1:0] SAT_RUN  = OW'(RUN + 1);

  logic [OW-1:0] ones_q, ones_n;

  always_comb begin
    ones_n = ones_q;
    sym    = SYM_NONE;
    if (bit_en) begin
      if (rx_bit) begin
        if (ones_q == ONE_RUN) begin
          sym    = SYM_ABORT;
          ones_n = SAT_RUN;
        end else if (ones_q != SAT_RUN) begin
          sym    = SYM_DATA;
          ones_n = ones_q + OW'(1);
        end
      end else begin
        ones_n = '0;
        if (ones_q == ONE_RUN)       sym = SYM_FLAG;
        else if (ones_q < STUF_RUN)  sym = SYM_DATA;
        // run of RUN-1 ones: inserted zero, dropped; saturated run: idle
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ones_q <= '0;
    else        ones_q <= ones_n;
  end
endmodule

// File: rtl/hdlc_rx_delay.sv
// Holds the newest DEPTH payload bits so that the leading bits of a
// closing delimiter never reach the byte assembler.
module hdlc_rx_delay #(
  parameter int DEPTH = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic push,
  input  logic din,
  output logic pop,
  output logic dout
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [DEPTH-1:0] dl_q, dl_n;
  logic [CW-1:0]    cnt_q, cnt_n;
  logic             full;

  assign full = (cnt_q == FULL);
  assign pop  = push & full;
  assign dout = dl_q[DEPTH-1];

  always_comb begin
    dl_n  = dl_q;
    cnt_n = cnt_q;
    if (clr) begin
      cnt_n = '0;
    end else if (push) begin
      dl_n = {dl_q[DEPTH-2:0], din};
      if (!full) cnt_n = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dl_q  <= '0;
      cnt_q <= '0;
    end else begin
      dl_q  <= dl_n;
      cnt_q <= cnt_n;
    end
  end
endmodule

// File: rtl/hdlc_rx_crc.sv
// Bit-serial reflected CRC with residue compare.
module hdlc_rx_crc
  import hdlc_rx_pkg::*;
#(
  parameter int W = CRC_W,
  parameter logic [W-1:0] POLY = CRC_POLY_R,
  parameter logic [W-1:0] SEED = CRC_SEED,
  parameter logic [W-1:0] GOOD = CRC_GOOD
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  input  logic din,
  output logic ok
);
  logic [W-1:0] crc_q, crc_n;
  logic         fb;

  assign fb = crc_q[0] ^ din;
  assign ok = (crc_q == GOOD);

  always_comb begin
    crc_n = crc_q;
    if (clr)     crc_n = SEED;
    else if (en) crc_n = (crc_q >> 1) ^ (fb ? POLY : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= SEED;
    else        crc_q <= crc_n;
  end
endmodule

// File: rtl/hdlc_rx_framer.sv
module hdlc_rx_framer
  import hdlc_rx_pkg::*;
#(
  parameter int LIMIT_W   = 16,
  parameter int MIN_BYTES = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bit_en,
  input  logic               rx_bit,
  input  logic               fcs_pass,
  input  logic [LIMIT_W-1:0] byte_limit,
  output logic               out_valid,
  output logic [BYTE_W-1:0]  out_data,
  output logic               out_sof,
  output logic               out_eof,
  output logic [ERR_W-1:0]   out_err
);
  localparam int CW    = LIMIT_W + 1;
  localparam int BCW   = $clog2(BYTE_W);
  localparam int DEPTH = FLAG_RUN + 1;
  localparam logic [BCW-1:0] LAST_BIT = BCW'(BYTE_W - 1);

  // reset synchronizer: asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  sym_e sym;
  logic in_frame, ev_flag, ev_abort, ev_data;
  logic pop, pop_bit, crc_ok;

  hdlc_rx_bitproc #(.RUN(FLAG_RUN)) u_bits (
    .clk(clk), .rst_n(rst_i_n), .bit_en(bit_en), .rx_bit(rx_bit), .sym(sym)
  );

  hdlc_rx_delay #(.DEPTH(DEPTH)) u_dly (
    .clk(clk), .rst_n(rst_i_n), .clr(ev_flag), .push(ev_data),
    .din(rx_bit), .pop(pop), .dout(pop_bit)
  );

  hdlc_rx_crc u_crc (
    .clk(clk), .rst_n(rst_i_n), .clr(ev_flag), .en(pop), .din(pop_bit),
    .ok(crc_ok)
  );

  rx_state_e                st_q, st_n;
  logic [BCW-1:0]           bcnt_q, bcnt_n;
  logic [BYTE_W-1:0]        sh_q, sh_n;
  logic                     any_q, any_n;
  logic [CW-1:0]            nb_q, nb_n;
  logic [1:0][BYTE_W-1:0]   hold_q, hold_n;
  logic [1:0]               hsof_q, hsof_n;
  logic [1:0]               hcnt_q, hcnt_n;
  logic                     tail_q, tail_n;
  logic [1:0]               tcnt_q, tcnt_n;
  logic [ERR_W-1:0]         terr_q, terr_n;
  logic                     ov_q, ov_n, os_q, os_n, oe_q, oe_n;
  logic [BYTE_W-1:0]        od_q, od_n;
  logic [ERR_W-1:0]         oerr_q, oerr_n;

  logic [BYTE_W-1:0] byte_new;
  logic [CW-1:0]     cnt_inc;
  logic              byte_done, ovf, end_ev;
  logic [ERR_W-1:0]  end_err;

  assign in_frame  = (st_q == ST_FRAME);
  assign ev_flag   = (sym == SYM_FLAG);
  assign ev_abort  = (sym == SYM_ABORT);
  assign ev_data   = (sym == SYM_DATA) & in_frame;
  assign byte_new  = {pop_bit, sh_q[BYTE_W-1:1]};
  assign byte_done = pop & (bcnt_q == LAST_BIT);
  assign cnt_inc   = nb_q + CW'(1);
  assign ovf       = byte_done & (cnt_inc > {1'b0, byte_limit});

  always_comb begin
    st_n   = st_q;   bcnt_n = bcnt_q; sh_n   = sh_q;   any_n  = any_q;
    nb_n   = nb_q;   hold_n = hold_q; hsof_n = hsof_q; hcnt_n = hcnt_q;
    tail_n = tail_q; tcnt_n = tcnt_q; terr_n = terr_q;
    ov_n   = 1'b0;   os_n   = 1'b0;   oe_n   = 1'b0;
    od_n   = od_q;   oerr_n = '0;
    end_ev = 1'b0;   end_err = '0;

    // end-of-frame flush: held bytes (if passed), then the status strobe
    if (tail_q) begin
      if (tcnt_q != 2'd0) begin
        ov_n      = 1'b1;
        od_n      = hold_q[0];
        os_n      = hsof_q[0];
        hold_n[0] = hold_q[1];
        hsof_n[0] = hsof_q[1];
        tcnt_n    = tcnt_q - 2'd1;
      end else begin
        oe_n   = 1'b1;
        oerr_n = terr_q;
        tail_n = 1'b0;
        hcnt_n = 2'd0;
      end
    end

    // byte assembly, LSB first
    if (pop) begin
      sh_n   = byte_new;
      bcnt_n = bcnt_q + BCW'(1);
      any_n  = 1'b1;
    end

    if (byte_done) begin
      if (ovf) begin
        end_ev          = 1'b1;
        end_err[E_OVF]  = 1'b1;
        st_n            = ST_HUNT;
      end else begin
        nb_n = cnt_inc;
        if (hcnt_q == 2'd2) begin
          ov_n      = 1'b1;
          od_n      = hold_q[0];
          os_n      = hsof_q[0];
          hold_n[0] = hold_q[1];
          hsof_n[0] = hsof_q[1];
          hold_n[1] = byte_new;
          hsof_n[1] = (nb_q == '0);
        end else begin
          hold_n[hcnt_q[0]] = byte_new;
          hsof_n[hcnt_q[0]] = (nb_q == '0);
          hcnt_n            = hcnt_q + 2'd1;
        end
      end
    end

    if (ev_abort && in_frame) begin
      st_n = ST_HUNT;
      if (any_q) begin
        end_ev           = 1'b1;
        end_err[E_ABORT] = 1'b1;
      end
    end

    if (ev_flag) begin
      if (in_frame && any_q) begin
        end_ev            = 1'b1;
        end_err[E_NONOCT] = (bcnt_q != '0);
        end_err[E_SHORT]  = (nb_q < CW'(MIN_BYTES));
        end_err[E_CRC]    = ~crc_ok;
      end
      st_n   = ST_FRAME;
      bcnt_n = '0;
      any_n  = 1'b0;
      nb_n   = '0;
    end

    if (end_ev) begin
      tail_n = 1'b1;
      tcnt_n = fcs_pass ? hcnt_q : 2'd0;
      terr_n = end_err;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st_n_reg_reset();
    end else begin
      st_q   <= st_n;   bcnt_q <= bcnt_n; sh_q   <= sh_n;   any_q  <= any_n;
      nb_q   <= nb_n;   hold_q <= hold_n; hsof_q <= hsof_n; hcnt_q <= hcnt_n;
      tail_q <= tail_n; tcnt_q <= tcnt_n; terr_q <= terr_n;
      ov_q   <= ov_n;   os_q   <= os_n;   oe_q   <= oe_n;
      od_q   <= od_n;   oerr_q <= oerr_n;
    end
  end

  task automatic st_n_reg_reset();
    st_q   <= ST_HUNT; bcnt_q <= '0; sh_q   <= '0; any_q  <= 1'b0;
    nb_q   <= '0;      hold_q <= '0; hsof_q <= '0; hcnt_q <= '0;
    tail_q <= 1'b0;    tcnt_q <= '0; terr_q <= '0;
    ov_q   <= 1'b0;    os_q   <= 1'b0; oe_q <= 1'b0;
    od_q   <= '0;      oerr_q <= '0;
  endtask

  assign out_valid = ov_q;
  assign out_data  = od_q;
  assign out_sof   = os_q;
  assign out_eof   = oe_q;
  assign out_err   = oerr_q;
endmodule

// File: rtl/hdlc_rx_framer_chk.sv
module hdlc_rx_framer_chk
  import hdlc_rx_pkg::*;
#(
  parameter int LIMIT_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic [LIMIT_W-1:0] byte_limit,
  input logic               out_valid,
  input logic               out_sof,
  input logic               out_eof,
  input logic [ERR_W-1:0]   out_err
);
  logic [LIMIT_W:0] dlv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         dlv_q <= '0;
    else if (out_eof)   dlv_q <= '0;
    else if (out_valid) dlv_q <= dlv_q + 1'b1;
  end

  assert_sof_on_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |-> out_valid);

  assert_eof_alone_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_eof |-> !out_valid);

  assert_err_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_eof |-> (out_err == '0));

  assert_eof_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_eof |=> !out_eof);

  assert_abort_alone_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_eof && out_err[E_ABORT]) |-> (out_err == ERR_W'(1 << E_ABORT)));

  assert_ovf_alone_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_eof && out_err[E_OVF]) |-> (out_err == ERR_W'(1 << E_OVF)));

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (dlv_q < {1'b0, byte_limit}));
endmodule

bind hdlc_rx_framer hdlc_rx_framer_chk #(.LIMIT_W(LIMIT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .byte_limit(byte_limit), .out_valid(out_valid),
  .out_sof(out_sof), .out_eof(out_eof), .out_err(out_err)
);

// File: tb/hdlc_rx_framer_tb.sv
module hdlc_rx_framer_tb;
  import hdlc_rx_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int CAP = 512;
  localparam int NVEC = 7;
  // {len, first, step, pass, corrupt, limit, expected error}
  localparam logic [46:0] VEC [NVEC] = '{
    {8'd6, 8'h31, 8'h11, 1'b0, 1'b0, 16'd100, 5'b00000},
    {8'd6, 8'h31, 8'h11, 1'b1, 1'b0, 16'd100, 5'b00000},
    {8'd3, 8'hA5, 8'h01, 1'b0, 1'b0, 16'd100, 5'b00000},
    {8'd2, 8'h5A, 8'h01, 1'b1, 1'b0, 16'd100, 5'b00100},
    {8'd5, 8'h10, 8'h03, 1'b0, 1'b1, 16'd100, 5'b10000},
    {8'd6, 8'hFF, 8'h00, 1'b1, 1'b0, 16'd100, 5'b00000},
    {8'd4, 8'h7E, 8'h00, 1'b0, 1'b0, 16'd6,   5'b00000}
  };

  logic clk, rst_n, bit_en, rx_bit, fcs_pass;
  logic [15:0] byte_limit;
  logic out_valid, out_sof, out_eof;
  logic [7:0] out_data;
  logic [ERR_W-1:0] out_err;

  int checks = 0, fails = 0, cap_n = 0, eof_n = 0, run = 0;
  logic [7:0] cap_d [CAP];
  logic       cap_s [CAP];
  logic [ERR_W-1:0] last_err = '0;
  logic [7:0] fr [32];
  bit done = 0;

  hdlc_rx_framer u_dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit),
    .fcs_pass(fcs_pass), .byte_limit(byte_limit), .out_valid(out_valid),
    .out_data(out_data), .out_sof(out_sof), .out_eof(out_eof), .out_err(out_err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        cap_d[cap_n % CAP] = out_data;
        cap_s[cap_n % CAP] = out_sof;
        cap_n++;
      end
      if (out_eof) begin
        eof_n++;
        last_err = out_err;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input logic b);
    rx_bit = b; bit_en = 1'b1;
    @(negedge clk);
    bit_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic send_flag();
    tick(1'b0);
    for (int i = 0; i < 6; i++) tick(1'b1);
    tick(1'b0);
    run = 0;
  endtask

  task automatic send_fbit(input logic b);
    tick(b);
    if (b) begin
      run++;
      if (run == 5) begin tick(1'b0); run = 0; end
    end else run = 0;
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) send_fbit(v[i]);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(1'b1);
    repeat (8) @(negedge clk);
  endtask

  function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] v);
    logic [15:0] r = c;
    for (int i = 0; i < 8; i++)
      r = (r >> 1) ^ ((r[0] ^ v[i]) ? 16'h8408 : 16'h0000);
    return r;
  endfunction

  task automatic build(input int len, input logic [7:0] st, input logic [7:0] stp,
                       input logic corrupt);
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < len; i++) begin
      fr[i] = st + 8'(i) * stp;
      c = crc_byte(c, fr[i]);
    end
    c = ~c;
    fr[len] = c[7:0];
    fr[len+1] = c[15:8];
    if (corrupt) fr[0] = fr[0] ^ 8'h01;
  endtask

  task automatic run_frame(input int len, input logic [7:0] st, input logic [7:0] stp,
                           input logic pass, input logic corrupt, input logic [15:0] lim,
                           input logic [4:0] exp_err, input int exp_n, input string tag);
    int base, e0, bad;
    build(len, st, stp, corrupt);
    fcs_pass = pass; byte_limit = lim;
    base = cap_n; e0 = eof_n;
    send_flag(); send_flag();
    for (int i = 0; i < len + 2; i++) send_byte(fr[i]);
    send_flag();
    idle(12);
    chk(eof_n == e0 + 1, {tag, " R1 one end strobe per frame"}, eof_n - e0, 1);
    chk(last_err == exp_err, {tag, " R4 R8 R10 error vector"}, last_err, exp_err);
    chk(cap_n - base == exp_n, {tag, " R5 delivered byte count"}, cap_n - base, exp_n);
    bad = 0;
    for (int i = 0; i < exp_n; i++)
      if (cap_d[(base+i) % CAP] !== fr[i] || cap_s[(base+i) % CAP] !== (i == 0)) bad++;
    chk(bad == 0, {tag, " R2 R3 payload bytes and start marker"}, bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int base, e0;
    rst_n = 1'b0; bit_en = 1'b0; rx_bit = 1'b1; fcs_pass = 1'b0; byte_limit = 16'd100;
    repeat (4) @(negedge clk);
    // R11: reset state
    chk({out_valid, out_sof, out_eof, out_err} == '0, "R11 outputs low in reset",
        {out_valid, out_sof, out_eof, out_err}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    idle(10);
    chk(eof_n == 0 && cap_n == 0, "R1 idle line gives no output", eof_n + cap_n, 0);

    for (int k = 0; k < NVEC; k++) begin
      logic [46:0] v = VEC[k];
      int len = int'(v[46:39]);
      run_frame(len, v[38:31], v[30:23], v[22], v[21], v[20:5], v[4:0],
                v[22] ? len + 2 : len, "vec");
    end

    // R9: limit overrun mid-frame, then a clean frame after it
    run_frame(8, 8'h10, 8'h01, 1'b1, 1'b0, 16'd4, 5'b01000, 4, "R9 overrun");
    run_frame(5, 8'h40, 8'h05, 1'b0, 1'b0, 16'd100, 5'b00000, 5, "R9 after overrun");

    // R6: abort after a partial byte
    fcs_pass = 1'b0; base = cap_n; e0 = eof_n;
    send_flag();
    send_byte(8'h12); send_byte(8'h34); send_byte(8'h56);
    for (int i = 0; i < 7; i++) tick(1'b1);
    idle(12);
    chk(eof_n == e0 + 1, "R6 abort gives one end strobe", eof_n - e0, 1);
    chk(last_err == 5'b00001, "R6 abort error vector", last_err, 1);
    chk(cap_n == base, "R6 R5 no bytes delivered on stripped abort", cap_n - base, 0);

    // R7: three stray bits before the closing delimiter
    build(6, 8'h21, 8'h07, 1'b0);
    fcs_pass = 1'b0; e0 = eof_n;
    send_flag();
    for (int i = 0; i < 8; i++) send_byte(fr[i]);
    send_fbit(1'b0); send_fbit(1'b1); send_fbit(1'b0);
    send_flag();
    idle(12);
    chk(eof_n == e0 + 1, "R7 one end strobe", eof_n - e0, 1);
    chk(last_err[E_NONOCT] == 1'b1, "R7 partial byte bit", last_err, 5'b00010);
    chk((last_err & 5'b01101) == 0, "R7 no short/abort/overrun bits", last_err, 5'b00010);

    // R1: a run of adjacent delimiters then a frame
    e0 = eof_n;
    send_flag(); send_flag(); send_flag();
    run_frame(4, 8'h81, 8'h02, 1'b1, 1'b0, 16'd100, 5'b00000, 6, "R1 adjacent delimiters");
    chk(eof_n == e0 + 1, "R1 adjacent delimiters add no strobe", eof_n - e0, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule